// File: doc/BRIEF.md
# Serial Crosspoint Configuration Loader

This block programs a chain of 16x16 analog crosspoint switch arrays from the host side. Each array takes its 256 switch-control bits through a three-wire link. The loader drives that link with a serial data line, a serial clock that captures on its rising edge, and an active-low load strobe. The strobe copies the shifted bits into the switch latches while it is low. A client places the complete connection matrix for every device on `matrix_i` and pulses `start_i`. The loader captures the matrix and shifts every bit with no gaps. It then waits a set time, pulses the strobe once, and raises `done_o` for one cycle.

Every timing interval is counted in system-clock cycles and set by a parameter. At elaboration the parameters are checked against the minimum serial clock high and low times, the lowest allowed serial clock rate, the strobe setup time and width, and the deadline for committing the data. Devices are cascaded by connecting each device's serial output to the next device's serial input. The data for the farthest device therefore leaves the loader first.

Top module: `xpt_cfg_loader`

## Requirements
- R1: Bit `matrix_i[d*256 + y*16 + x]` controls the switch at row y, column x of device d, where device 0 is the one wired to the loader. A 1 closes the switch and a 0 opens it. Bits leave in descending flat index order, from index 256*N_DEV-1 (farthest device, row 15, column 15) down to index 0.
- R2: One load produces exactly 256*N_DEV rising edges of `sclk_o`, with no pause between bits.
- R3: `sdo_o` changes only on a cycle where `sclk_o` falls or leaves idle. It is stable for at least HALF_CYC cycles before each rising edge and through the whole high phase.
- R4: During a frame, every high phase and every low phase between bits of `sclk_o` lasts exactly HALF_CYC cycles.
- R5: `stb_n_o` falls exactly GAP_CYC cycles after the last falling edge of `sclk_o` and stays low for exactly STB_CYC cycles.
- R6: The strobe goes low and returns high within 5 ms of the last serial edge. At elaboration, parameters are rejected that break this deadline, the 100 ns minimum for the clock high time and low time, the 20 kHz minimum clock rate, or the 65 ns minimum for strobe setup and width.
- R7: After reset and while idle, `sclk_o`=0, `sdo_o`=0, `stb_n_o`=1 and `done_o`=0, and no serial clock edge occurs.
- R8: A `start_i` pulse while a load is in progress is ignored. It does not change the data shifted, the number of edges or the number of strobes.
- R9: `done_o` is high for exactly one cycle, the cycle after `stb_n_o` returns high.
- R10: Each load issues exactly one strobe pulse, and `sclk_o` stays low while `stb_n_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to begin a load |
| matrix_i | input | 256*N_DEV | Connection matrix for all devices, captured when a load starts |
| sclk_o | output | 1 | Serial clock to the chain, capture on rising edge |
| sdo_o | output | 1 | Serial data to the first device |
| stb_n_o | output | 1 | Active-low load strobe |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
A start request can arrive in the same cycle as the loader's own phase transitions: during shifting, on the edge that ends the last high phase, or during the strobe, release or done cycle. The bench issues a second start with a different matrix in the middle of a frame, and a third while the strobe is still low. It then checks that the latches of the modelled device chain hold only the first matrix, and that exactly one strobe, one done pulse and 256*N_DEV serial edges were seen. Every frame is also checked with a device model that captures bits on the serial clock and copies them while the strobe is low, and with monitors that measure every phase width in cycles.

// File: rtl/xpt_cfg_pkg.sv
package xpt_cfg_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_LO,
    S_HI,
    S_GAP,
    S_STB,
    S_REL,
    S_FIN
  } xpt_state_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/xpt_phase_timer.sv
module xpt_phase_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)          cnt_d = val_i;
    else if (cnt_q != 0) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/xpt_bit_feeder.sv
module xpt_bit_feeder #(
  parameter int TOT = 512
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load_i,
  input  logic           adv_i,
  input  logic [TOT-1:0] mat_i,
  output logic           bit_o,
  output logic           last_o
);

  localparam int IW = $clog2(TOT);

  logic [TOT-1:0] mat_q;
  logic [IW-1:0]  idx_q, idx_d;

  always_comb begin
    idx_d = idx_q;
    if (load_i)     idx_d = IW'(TOT - 1);
    else if (adv_i) idx_d = idx_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= '0;
    else             idx_q <= idx_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mat_q <= '0;
    else if (load_i) mat_q <= mat_i;
  end

  assign bit_o  = mat_q[idx_q];
  assign last_o = (idx_q == '0);

  // R2: the sequencer never steps past the final bit of a frame
  assert_no_underrun_R2: assert property (@(posedge clk) disable iff (!rst_n)
    adv_i |-> (idx_q != '0));

endmodule

// File: rtl/xpt_cfg_loader.sv
module xpt_cfg_loader
  import xpt_cfg_pkg::*;
#(
  parameter int N_DEV    = 2,
  parameter int CLK_PS   = 5000,
  parameter int HALF_CYC = 20,
  parameter int GAP_CYC  = 14,
  parameter int STB_CYC  = 14
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start_i,
  input  logic [256*N_DEV-1:0]   matrix_i,
  output logic                   sclk_o,
  output logic                   sdo_o,
  output logic                   stb_n_o,
  output logic                   done_o
);

  localparam int TOT  = 256 * N_DEV;
  localparam int TMAX = max3(HALF_CYC, GAP_CYC, STB_CYC);
  localparam int TW   = $clog2(TMAX + 1);

  // R6: parameter limits checked at elaboration
  initial begin
    assert_sclk_phase_min_R6: assert (longint'(HALF_CYC) * CLK_PS >= 64'd100000)
      else $error("serial clock phase shorter than 100 ns");
    assert_sclk_rate_min_R6: assert (longint'(2 * HALF_CYC) * CLK_PS <= 64'd50000000)
      else $error("serial clock slower than 20 kHz");
    assert_stb_setup_min_R6: assert (longint'(GAP_CYC) * CLK_PS >= 64'd65000)
      else $error("strobe setup shorter than 65 ns");
    assert_stb_width_min_R6: assert (longint'(STB_CYC) * CLK_PS >= 64'd65000)
      else $error("strobe width shorter than 65 ns");
    assert_stb_deadline_R6: assert (longint'(GAP_CYC + STB_CYC + 2) * CLK_PS + longint'(HALF_CYC) * CLK_PS
                                    <= 64'd5000000000)
      else $error("strobe deadline exceeds 5 ms");
  end

  xpt_state_e    state_q, state_d;
  logic          tmr_load, tmr_zero;
  logic [TW-1:0] tmr_val;
  logic          feed_load, feed_adv, feed_bit, feed_last;
  logic          sclk_q, sdo_q, stb_n_q, done_q;
  logic          sclk_d, sdo_d, stb_n_d, done_d;

  xpt_phase_timer #(.W(TW)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .zero_o (tmr_zero)
  );

  xpt_bit_feeder #(.TOT(TOT)) u_feeder (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (feed_load),
    .adv_i  (feed_adv),
    .mat_i  (matrix_i),
    .bit_o  (feed_bit),
    .last_o (feed_last)
  );

  always_comb begin
    state_d   = state_q;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    feed_load = 1'b0;
    feed_adv  = 1'b0;
    unique case (state_q)
      S_IDLE: if (start_i) begin
        feed_load = 1'b1;
        tmr_load  = 1'b1;
        tmr_val   = TW'(HALF_CYC - 1);
        state_d   = S_LO;
      end
      S_LO: if (tmr_zero) begin
        tmr_load = 1'b1;
        tmr_val  = TW'(HALF_CYC - 1);
        state_d  = S_HI;
      end
      S_HI: if (tmr_zero) begin
        tmr_load = 1'b1;
        if (feed_last) begin
          tmr_val = TW'(GAP_CYC - 1);
          state_d = S_GAP;
        end else begin
          feed_adv = 1'b1;
          tmr_val  = TW'(HALF_CYC - 1);
          state_d  = S_LO;
        end
      end
      S_GAP: if (tmr_zero) begin
        tmr_load = 1'b1;
        tmr_val  = TW'(STB_CYC - 1);
        state_d  = S_STB;
      end
      S_STB: if (tmr_zero) state_d = S_REL;
      S_REL: state_d = S_FIN;
      S_FIN: state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= S_IDLE;
    else        state_q <= state_d;
  end

  // pin drivers are registered: every pin lags the state by one cycle
  always_comb begin
    sclk_d  = (state_q == S_HI);
    sdo_d   = ((state_q == S_LO) || (state_q == S_HI)) ? feed_bit : 1'b0;
    stb_n_d = (state_q != S_STB);
    done_d  = (state_q == S_FIN);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q  <= 1'b0;
      sdo_q   <= 1'b0;
      stb_n_q <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      sclk_q  <= sclk_d;
      sdo_q   <= sdo_d;
      stb_n_q <= stb_n_d;
      done_q  <= done_d;
    end
  end

  assign sclk_o  = sclk_q;
  assign sdo_o   = sdo_q;
  assign stb_n_o = stb_n_q;
  assign done_o  = done_q;

  assert_sdo_hold_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_q |-> $stable(sdo_q));

  assert_no_clk_in_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !stb_n_q |-> !sclk_q);

  assert_done_after_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stb_n_q) |=> done_q);

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  assert_busy_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q inside {S_GAP, S_STB, S_REL, S_FIN}) && start_i) |=> (state_q != S_LO));

endmodule

// File: tb/xpt_cfg_loader_bench.sv
module xpt_cfg_loader_bench;

  localparam int N_DEV = 2;
  localparam int TOT   = 256 * N_DEV;
  localparam int HALF  = 20;
  localparam int GAP   = 14;
  localparam int STBW  = 14;

  logic           clk, rst_n, start_i;
  logic [TOT-1:0] matrix_i;
  logic           sclk_o, sdo_o, stb_n_o, done_o;

  xpt_cfg_loader #(.N_DEV(N_DEV), .CLK_PS(5000), .HALF_CYC(HALF), .GAP_CYC(GAP), .STB_CYC(STBW))
    u_xpt_cfg_loader (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .matrix_i(matrix_i),
      .sclk_o(sclk_o), .sdo_o(sdo_o), .stb_n_o(stb_n_o), .done_o(done_o));

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  int cycles = 0;

  // device chain model and monitors, sampled on the falling system edge
  logic [TOT-1:0] chain, latch;
  logic p_sclk = 1'b0, p_stb = 1'b1, p2_stb = 1'b1, p_sdo = 1'b0, p_done = 1'b0;
  int rise_cnt, hi_run, lo_run, sdo_run, width_err, sdo_err;
  int gap_cnt, gap_meas, stb_run, stb_meas, stb_cnt, done_cnt, done_err, clk_in_stb;

  task automatic clear_mon();
    rise_cnt = 0; width_err = 0; sdo_err = 0; gap_meas = -1; stb_meas = -1;
    stb_cnt = 0; done_cnt = 0; done_err = 0; clk_in_stb = 0;
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      if (sdo_o != p_sdo) begin
        if (!(p_sclk && !sclk_o) && !(sclk_o && p_sclk == 1'b0 && 1'b0)) begin
          if (sclk_o || p_sclk) sdo_err++;
        end
        sdo_run = 0;
      end else sdo_run++;
      if (sclk_o && !p_sclk) begin
        if (rise_cnt > 0 && lo_run != HALF) width_err++;
        if (sdo_run < HALF) sdo_err++;
        rise_cnt++;
        hi_run = 1;
        chain = {chain[TOT-2:0], sdo_o};
      end else if (sclk_o) hi_run++;
      if (!sclk_o && p_sclk) begin
        if (hi_run != HALF) width_err++;
        lo_run = 1;
        gap_cnt = 0;
      end else if (!sclk_o) begin
        lo_run++;
        gap_cnt++;
      end
      if (!stb_n_o && p_stb) begin
        gap_meas = gap_cnt;
        stb_run = 1;
        stb_cnt++;
      end else if (!stb_n_o) stb_run++;
      if (stb_n_o && !p_stb) stb_meas = stb_run;
      if (!stb_n_o) begin
        latch = chain;
        if (sclk_o) clk_in_stb++;
      end
      if (done_o) begin
        done_cnt++;
        if (!(p_stb && !p2_stb) || p_done) done_err++;
      end
    end
    p2_stb = p_stb; p_stb = stb_n_o; p_sclk = sclk_o; p_sdo = sdo_o; p_done = done_o;
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (done_cnt == 0 && n < 40000) begin
      @(negedge clk); n++;
    end
    repeat (20) @(negedge clk);
  endtask

  // mode 0: plain load; 1: extra start mid-shift; 2: extra start during strobe
  task automatic run_load(input logic [TOT-1:0] m, input int mode);
    logic [TOT-1:0] other;
    other = ~m ^ {TOT/32{32'h1357_9bdf}};
    clear_mon();
    matrix_i = m;
    pulse_start();
    if (mode == 1) begin
      repeat (3000) @(negedge clk);
      matrix_i = other;
      pulse_start();
    end else if (mode == 2) begin
      while (stb_n_o) @(negedge clk);
      matrix_i = other;
      start_i = 1'b1;
      @(negedge clk); start_i = 1'b0;
    end
    wait_done();
    for (int d = 0; d < N_DEV; d++)
      check(latch[d*256 +: 256] == m[d*256 +: 256], "R1 latch match", d, d);
    check(rise_cnt == TOT, "R2 edge count", rise_cnt, TOT);
    check(sdo_err == 0, "R3 data setup/hold", sdo_err, 0);
    check(width_err == 0, "R4 phase widths", width_err, 0);
    check(gap_meas == GAP, "R5 strobe setup", gap_meas, GAP);
    check(stb_meas == STBW, "R5 strobe width", stb_meas, STBW);
    check((gap_meas + stb_meas) * 5 < 5000000, "R6 deadline ns", (gap_meas + stb_meas) * 5, 5000000);
    check(done_cnt == 1 && done_err == 0, "R9 done pulse", done_cnt, 1);
    check(stb_cnt == 1, "R10 single strobe", stb_cnt, 1);
    check(clk_in_stb == 0, "R10 clock during strobe", clk_in_stb, 0);
    if (mode != 0) check(stb_cnt == 1 && rise_cnt == TOT, "R8 busy start ignored", stb_cnt, 1);
    check(!sclk_o && stb_n_o && !sdo_o && !done_o, "R7 idle after load",
          {sclk_o, stb_n_o, sdo_o, done_o}, 4'b0100);
  endtask

  function automatic logic [TOT-1:0] rand_mat();
    logic [TOT-1:0] r;
    for (int w = 0; w < TOT / 32; w++) r[w*32 +: 32] = $urandom;
    return r;
  endfunction

  function automatic logic [TOT-1:0] diag_mat();
    logic [TOT-1:0] r = '0;
    for (int d = 0; d < N_DEV; d++)
      for (int y = 0; y < 16; y++) r[d*256 + y*16 + ((y + d) % 16)] = 1'b1;
    return r;
  endfunction

  initial begin
    rst_n = 1'b0; start_i = 1'b0; matrix_i = '0;
    chain = '0; latch = '0;
    hi_run = 0; lo_run = 0; sdo_run = 0; gap_cnt = 0; stb_run = 0;
    clear_mon();
    void'($urandom(32'h0bad_5eed));
    repeat (5) @(negedge clk);
    check(!sclk_o && stb_n_o && !sdo_o && !done_o, "R7 reset levels",
          {sclk_o, stb_n_o, sdo_o, done_o}, 4'b0100);
    rst_n = 1'b1;
    repeat (50) @(negedge clk);
    check(rise_cnt == 0 && stb_cnt == 0, "R7 idle no activity", rise_cnt, 0);
    run_load({TOT{1'b1}}, 0);
    run_load(diag_mat(), 0);
    run_load(rand_mat(), 1);
    run_load(rand_mat(), 2);
    run_load(rand_mat(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles >= 190000);
    checks++; errors++;
    $display("FAIL watchdog: actual %0d expected %0d", cycles, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule